// File: doc/BRIEF.md
# Uncached and Cache-Maintenance Store Sequencer

This controller runs the store at the head of the store queue when that store cannot go through the cached path. It handles three kinds of store: a memory-mapped I/O store, a non-cacheable store and a cache-maintenance operation. Each cycle the surrounding queue presents the head entry's kind and its qualifiers. These are whether the entry has reached the head of the reorder buffer, whether it has been committed, and how many committed older stores still wait to drain into the store buffer. The sequencer then drives the matching channel, writes the result back to the reorder buffer and pulses a dequeue when it is finished with the entry.

Two state machines share the work. The main machine serves I/O stores and cache-maintenance operations and has the states IDLE, REQ, RESP, WB and WAIT. Its transitions are:
- start (IDLE to REQ)
- accept (REQ to RESP)
- respond (RESP to WB)
- fault-exit (WB to IDLE, taken when the response carried an error)
- park (WB to WAIT)
- commit-exit (WAIT to IDLE, or WB to IDLE for a maintenance operation)

For a maintenance operation, REQ first asks the store buffer to flush and only then issues the request. The non-cacheable machine has the states NC_IDLE, NC_REQ and NC_RESP. Its transitions are:
- nc-start (NC_IDLE to NC_REQ)
- nc-accept (NC_REQ to NC_RESP, or straight back to NC_IDLE when the `OUTSTANDING` parameter is set)
- nc-respond (NC_RESP to NC_IDLE)

A head cancel (`head_flush`) sends either machine from REQ, WB or WAIT back to idle without a dequeue. It has no effect while a machine waits in a RESP state.

Top module: `store_seq_top`

## Requirements
- R1: After reset both machines are idle and all outputs (`mmio_req_valid`, `cmo_req_valid`, `sbf_flush_req`, `nc_req_valid`, `wb_valid`, `wb_exc`, `deq`) are 0.
- R2: The main machine takes start when all of the following hold in the same cycle: `head_valid` is 1, `head_kind` is 2'b01 (I/O) or 2'b11 (maintenance), `rob_at_head` is 1, `older_pending` is 0, the NC machine is idle and `head_flush` is 0. In the next cycle it is in REQ.
- R3: For an I/O store, REQ drives `mmio_req_valid` until a cycle in which `mmio_req_ready` is 1. It then waits in RESP for `mmio_resp_valid` and records `mmio_resp_err` from that cycle.
- R4: For an I/O store, WB drives `wb_valid` for exactly one cycle, with `wb_exc` equal to the recorded error. When the error is set, `deq` pulses in that same cycle and the machine goes idle. Otherwise it parks in WAIT and pulses `deq` in the cycle in which `rob_commit` is 1.
- R5: For a maintenance operation, REQ drives `sbf_flush_req` until `sbf_flush_done` is seen. From the following cycle it drives `cmo_req_valid` until `cmo_req_ready`, then waits in RESP for `cmo_resp_valid`.
- R6: For a maintenance operation, WB drives `wb_valid` only in its first cycle, with `wb_exc` 0. The machine stays in WB until `rob_commit`, and `deq` pulses in that cycle.
- R7: The NC machine takes nc-start when `head_valid` is 1, `head_kind` is 2'b10, `head_committed` is 1, the main machine is idle and `head_flush` is 0. In NC_REQ it drives `nc_req_valid` until `nc_req_ready`.
- R8: When `OUTSTANDING` is 0, `deq` pulses in the cycle in which `nc_resp_valid` arrives in NC_RESP. When `OUTSTANDING` is 1, `deq` pulses in the cycle the request is accepted, and the machine returns to idle.
- R9: At most one machine is out of idle at any time, and `deq` never stays high for two consecutive cycles.
- R10: `head_flush` in REQ, WB or WAIT forces all outputs to 0 in that cycle and returns the machine to idle. It is ignored in RESP and NC_RESP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Queue head holds a live entry |
| head_kind | input | 2 | 00 cached, 01 I/O, 10 non-cacheable, 11 maintenance |
| rob_at_head | input | 1 | Head store is at the reorder-buffer head |
| head_committed | input | 1 | Head store has been committed |
| older_pending | input | CNT_W | Committed older stores not yet in the store buffer |
| head_flush | input | 1 | Pipeline flush cancels the head entry |
| mmio_req_valid | output | 1 | I/O channel request |
| mmio_req_ready | input | 1 | I/O channel accepts the request |
| mmio_resp_valid | input | 1 | I/O channel response |
| mmio_resp_err | input | 1 | I/O response carries an error |
| nc_req_valid | output | 1 | Non-cacheable channel request |
| nc_req_ready | input | 1 | Non-cacheable channel accepts the request |
| nc_resp_valid | input | 1 | Non-cacheable channel response |
| cmo_req_valid | output | 1 | Maintenance channel request |
| cmo_req_ready | input | 1 | Maintenance channel accepts the request |
| cmo_resp_valid | input | 1 | Maintenance channel response |
| sbf_flush_req | output | 1 | Ask the store buffer to drain |
| sbf_flush_done | input | 1 | Store buffer drain finished |
| rob_commit | input | 1 | Reorder buffer commits the head store |
| wb_valid | output | 1 | Writeback to the reorder buffer |
| wb_exc | output | 1 | Writeback carries an exception |
| deq | output | 1 | Head entry may leave the queue |

## Verification
The bench aims at the cycle in which a start is blocked by a single pending older store or by the other machine still being busy. A design that skipped either check would raise a request one cycle early. It also hits an error in the I/O response, where a design that parked in WAIT would hold the dequeue until a commit that never comes. For a maintenance operation, a flush-done pulse that arrives with the channel ready would expose a request issued in the same cycle as the drain. A cancel that lands in RESP would reveal a design that drops an outstanding response and loses track of the channel. Two instances run with the outstanding option off and on, so a dequeue on the wrong side of the non-cacheable response shows up as a one-cycle mismatch.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
    typedef enum logic [1:0] {
        KIND_CACHED = 2'b00,
        KIND_MMIO   = 2'b01,
        KIND_NC     = 2'b10,
        KIND_CMO    = 2'b11
    } head_kind_e;

    typedef enum logic [2:0] {
        M_IDLE, M_REQ, M_RESP, M_WB, M_WAIT
    } main_state_e;

    typedef enum logic [1:0] {
        NC_IDLE, NC_REQ, NC_RESP
    } nc_state_e;
endpackage

// File: rtl/store_seq_main_fsm.sv
module store_seq_main_fsm
    import store_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_is_cmo,
    input  logic cancel,
    input  logic mmio_req_ready,
    input  logic mmio_resp_valid,
    input  logic mmio_resp_err,
    input  logic cmo_req_ready,
    input  logic cmo_resp_valid,
    input  logic sbf_flush_done,
    input  logic rob_commit,
    output logic mmio_req_valid,
    output logic cmo_req_valid,
    output logic sbf_flush_req,
    output logic wb_valid,
    output logic wb_exc,
    output logic deq,
    output logic idle
);
    main_state_e state_q, state_d;
    logic is_cmo_q, is_cmo_d;
    logic drained_q, drained_d;
    logic wb_sent_q, wb_sent_d;
    logic exc_q, exc_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= M_IDLE;
            is_cmo_q  <= 1'b0;
            drained_q <= 1'b0;
            wb_sent_q <= 1'b0;
            exc_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            is_cmo_q  <= is_cmo_d;
            drained_q <= drained_d;
            wb_sent_q <= wb_sent_d;
            exc_q     <= exc_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d        = state_q;
        is_cmo_d       = is_cmo_q;
        drained_d      = drained_q;
        wb_sent_d      = wb_sent_q;
        exc_d          = exc_q;
        mmio_req_valid = 1'b0;
        cmo_req_valid  = 1'b0;
        sbf_flush_req  = 1'b0;
        wb_valid       = 1'b0;
        wb_exc         = 1'b0;
        deq            = 1'b0;
        idle           = (state_q == M_IDLE);
        unique case (state_q)
            M_IDLE: begin
                if (start) begin
                    state_d   = M_REQ;
                    is_cmo_d  = start_is_cmo;
                    drained_d = 1'b0;
                    wb_sent_d = 1'b0;
                    exc_d     = 1'b0;
                end
            end
            M_REQ: begin
                if (cancel) begin
                    state_d = M_IDLE;
                end else if (!is_cmo_q) begin
                    mmio_req_valid = 1'b1;
                    if (mmio_req_ready) state_d = M_RESP;
                end else if (!drained_q) begin
                    sbf_flush_req = 1'b1;
                    if (sbf_flush_done) drained_d = 1'b1;
                end else begin
                    cmo_req_valid = 1'b1;
                    if (cmo_req_ready) state_d = M_RESP;
                end
            end
            M_RESP: begin
                if (!is_cmo_q && mmio_resp_valid) begin
                    exc_d   = mmio_resp_err;
                    state_d = M_WB;
                end else if (is_cmo_q && cmo_resp_valid) begin
                    exc_d   = 1'b0;
                    state_d = M_WB;
                end
            end
            M_WB: begin
                if (cancel) begin
                    state_d = M_IDLE;
                end else if (!is_cmo_q) begin
                    wb_valid = 1'b1;
                    wb_exc   = exc_q;
                    if (exc_q) begin
                        deq     = 1'b1;
                        state_d = M_IDLE;
                    end else begin
                        state_d = M_WAIT;
                    end
                end else begin
                    wb_valid  = !wb_sent_q;
                    wb_sent_d = 1'b1;
                    if (rob_commit) begin
                        deq     = 1'b1;
                        state_d = M_IDLE;
                    end
                end
            end
            M_WAIT: begin
                if (cancel) begin
                    state_d = M_IDLE;
                end else if (rob_commit) begin
                    deq     = 1'b1;
                    state_d = M_IDLE;
                end
            end
            default: state_d = M_IDLE;
        endcase
    end
endmodule

// File: rtl/store_seq_nc_fsm.sv
module store_seq_nc_fsm
    import store_seq_pkg::*;
#(
    parameter bit OUTSTANDING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    input  logic nc_req_ready,
    input  logic nc_resp_valid,
    output logic nc_req_valid,
    output logic deq,
    output logic idle
);
    nc_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NC_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        nc_req_valid = 1'b0;
        deq          = 1'b0;
        idle         = (state_q == NC_IDLE);
        unique case (state_q)
            NC_IDLE: if (start) state_d = NC_REQ;
            NC_REQ: begin
                if (cancel) begin
                    state_d = NC_IDLE;
                end else begin
                    nc_req_valid = 1'b1;
                    if (nc_req_ready) begin
                        if (OUTSTANDING) begin
                            deq     = 1'b1;
                            state_d = NC_IDLE;
                        end else begin
                            state_d = NC_RESP;
                        end
                    end
                end
            end
            NC_RESP: begin
                if (nc_resp_valid) begin
                    deq     = 1'b1;
                    state_d = NC_IDLE;
                end
            end
            default: state_d = NC_IDLE;
        endcase
    end
endmodule

// File: rtl/store_seq_top.sv
module store_seq_top
    import store_seq_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter bit OUTSTANDING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [1:0]       head_kind,
    input  logic             rob_at_head,
    input  logic             head_committed,
    input  logic [CNT_W-1:0] older_pending,
    input  logic             head_flush,
    output logic             mmio_req_valid,
    input  logic             mmio_req_ready,
    input  logic             mmio_resp_valid,
    input  logic             mmio_resp_err,
    output logic             nc_req_valid,
    input  logic             nc_req_ready,
    input  logic             nc_resp_valid,
    output logic             cmo_req_valid,
    input  logic             cmo_req_ready,
    input  logic             cmo_resp_valid,
    output logic             sbf_flush_req,
    input  logic             sbf_flush_done,
    input  logic             rob_commit,
    output logic             wb_valid,
    output logic             wb_exc,
    output logic             deq
);
    logic m_idle, n_idle;
    logic m_deq, n_deq;
    logic kind_main, kind_nc, m_start, n_start;

    assign kind_main = (head_kind == KIND_MMIO) || (head_kind == KIND_CMO);
    assign kind_nc   = (head_kind == KIND_NC);
    assign m_start   = head_valid && kind_main && rob_at_head &&
                       (older_pending == '0) && n_idle && !head_flush;
    assign n_start   = head_valid && kind_nc && head_committed &&
                       m_idle && !head_flush;

    store_seq_main_fsm u_main (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (m_start),
        .start_is_cmo    (head_kind == KIND_CMO),
        .cancel          (head_flush),
        .mmio_req_ready  (mmio_req_ready),
        .mmio_resp_valid (mmio_resp_valid),
        .mmio_resp_err   (mmio_resp_err),
        .cmo_req_ready   (cmo_req_ready),
        .cmo_resp_valid  (cmo_resp_valid),
        .sbf_flush_done  (sbf_flush_done),
        .rob_commit      (rob_commit),
        .mmio_req_valid  (mmio_req_valid),
        .cmo_req_valid   (cmo_req_valid),
        .sbf_flush_req   (sbf_flush_req),
        .wb_valid        (wb_valid),
        .wb_exc          (wb_exc),
        .deq             (m_deq),
        .idle            (m_idle)
    );

    store_seq_nc_fsm #(.OUTSTANDING(OUTSTANDING)) u_nc (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (n_start),
        .cancel        (head_flush),
        .nc_req_ready  (nc_req_ready),
        .nc_resp_valid (nc_resp_valid),
        .nc_req_valid  (nc_req_valid),
        .deq           (n_deq),
        .idle          (n_idle)
    );

    assign deq = m_deq || n_deq;
endmodule

// File: rtl/store_seq_chk.sv
module store_seq_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             head_flush,
    input logic             rob_at_head,
    input logic [CNT_W-1:0] older_pending,
    input logic             mmio_req_valid,
    input logic             mmio_req_ready,
    input logic             cmo_req_valid,
    input logic             sbf_flush_done,
    input logic             wb_valid,
    input logic             deq,
    input logic             m_idle,
    input logic             n_idle
);
    // R9: only one machine busy
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !m_idle |-> n_idle);

    // R9: dequeue is a single-cycle pulse
    a_r9_deq_single: assert property (@(posedge clk) disable iff (!rst_n)
        deq |=> !deq);

    // R4 / R6: writeback lasts one cycle
    a_r4_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R3: an I/O request is held until accepted or cancelled
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_req_valid && !mmio_req_ready && !head_flush |=> mmio_req_valid || head_flush);

    // R2: an I/O request first appears only after a legal start
    a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mmio_req_valid) |-> $past(rob_at_head) && ($past(older_pending) == '0));

    // R5: maintenance request follows a completed drain
    a_r5_cmo_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmo_req_valid) |-> $past(sbf_flush_done));
endmodule

bind store_seq_top store_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/store_seq_top_tb.sv
module store_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int N_CYCLES   = 4000;

    logic clk = 1'b0;
    logic rst_n;
    logic head_valid, rob_at_head, head_committed, head_flush;
    logic [1:0] head_kind;
    logic [CNT_W-1:0] older_pending;
    logic mmio_req_ready, mmio_resp_valid, mmio_resp_err;
    logic nc_req_ready, nc_resp_valid, cmo_req_ready, cmo_resp_valid;
    logic sbf_flush_done, rob_commit;
    logic [6:0] act [2];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_seq_top #(.CNT_W(CNT_W), .OUTSTANDING(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_kind(head_kind),
        .rob_at_head(rob_at_head), .head_committed(head_committed),
        .older_pending(older_pending), .head_flush(head_flush),
        .mmio_req_valid(act[0][6]), .mmio_req_ready(mmio_req_ready),
        .mmio_resp_valid(mmio_resp_valid), .mmio_resp_err(mmio_resp_err),
        .nc_req_valid(act[0][3]), .nc_req_ready(nc_req_ready), .nc_resp_valid(nc_resp_valid),
        .cmo_req_valid(act[0][5]), .cmo_req_ready(cmo_req_ready), .cmo_resp_valid(cmo_resp_valid),
        .sbf_flush_req(act[0][4]), .sbf_flush_done(sbf_flush_done), .rob_commit(rob_commit),
        .wb_valid(act[0][2]), .wb_exc(act[0][1]), .deq(act[0][0]));

    store_seq_top #(.CNT_W(CNT_W), .OUTSTANDING(1'b1)) u_dut_os (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_kind(head_kind),
        .rob_at_head(rob_at_head), .head_committed(head_committed),
        .older_pending(older_pending), .head_flush(head_flush),
        .mmio_req_valid(act[1][6]), .mmio_req_ready(mmio_req_ready),
        .mmio_resp_valid(mmio_resp_valid), .mmio_resp_err(mmio_resp_err),
        .nc_req_valid(act[1][3]), .nc_req_ready(nc_req_ready), .nc_resp_valid(nc_resp_valid),
        .cmo_req_valid(act[1][5]), .cmo_req_ready(cmo_req_ready), .cmo_resp_valid(cmo_resp_valid),
        .sbf_flush_req(act[1][4]), .sbf_flush_done(sbf_flush_done), .rob_commit(rob_commit),
        .wb_valid(act[1][2]), .wb_exc(act[1][1]), .deq(act[1][0]));

    // behavioural reference: 0 idle, 1 req, 2 resp, 3 wb, 4 wait
    int  ms [2];
    int  ns [2];
    bit  m_cmo [2], m_drained [2], m_wbs [2], m_exc [2];
    bit  [6:0] exp_o [2];

    function automatic string tag_of(int b);
        case (b)
            6: return "R2 R3 R10 mmio_req_valid";
            5: return "R5 R10 cmo_req_valid";
            4: return "R5 sbf_flush_req";
            3: return "R7 R10 nc_req_valid";
            2: return "R4 R6 wb_valid";
            1: return "R4 wb_exc";
            default: return "R4 R6 R8 R9 deq";
        endcase
    endfunction

    task automatic model_out(input int k);
        bit fl = head_flush;
        bit os = (k == 1);
        bit [6:0] o = '0;
        o[6] = !fl && ms[k] == 1 && !m_cmo[k];
        o[4] = !fl && ms[k] == 1 && m_cmo[k] && !m_drained[k];
        o[5] = !fl && ms[k] == 1 && m_cmo[k] && m_drained[k];
        o[3] = !fl && ns[k] == 1;
        o[2] = !fl && ms[k] == 3 && (!m_cmo[k] || !m_wbs[k]);
        o[1] = o[2] && !m_cmo[k] && m_exc[k];
        o[0] = (!fl && ms[k] == 3 && !m_cmo[k] && m_exc[k]) ||
               (!fl && ms[k] == 3 && m_cmo[k] && rob_commit) ||
               (!fl && ms[k] == 4 && rob_commit) ||
               (!fl && ns[k] == 1 && nc_req_ready && os) ||
               (ns[k] == 2 && nc_resp_valid);
        exp_o[k] = o;
    endtask

    task automatic model_step(input int k);
        bit fl = head_flush;
        bit os = (k == 1);
        int nm = ms[k];
        int nn = ns[k];
        case (ms[k])
            0: if (head_valid && head_kind[0] && rob_at_head && older_pending == 0 &&
                   ns[k] == 0 && !fl) begin
                   nm = 1; m_cmo[k] = head_kind[1]; m_drained[k] = 0; m_wbs[k] = 0; m_exc[k] = 0;
               end
            1: if (fl) nm = 0;
               else if (!m_cmo[k]) begin if (mmio_req_ready) nm = 2; end
               else if (!m_drained[k]) begin if (sbf_flush_done) m_drained[k] = 1; end
               else if (cmo_req_ready) nm = 2;
            2: if (!m_cmo[k] && mmio_resp_valid) begin m_exc[k] = mmio_resp_err; nm = 3; end
               else if (m_cmo[k] && cmo_resp_valid) begin m_exc[k] = 0; nm = 3; end
            3: if (fl) nm = 0;
               else if (!m_cmo[k]) nm = m_exc[k] ? 0 : 4;
               else begin m_wbs[k] = 1; if (rob_commit) nm = 0; end
            default: if (fl || rob_commit) nm = 0;
        endcase
        case (ns[k])
            0: if (head_valid && head_kind == 2'b10 && head_committed && ms[k] == 0 && !fl) nn = 1;
            1: if (fl) nn = 0; else if (nc_req_ready) nn = os ? 0 : 2;
            default: if (nc_resp_valid) nn = 0;
        endcase
        ms[k] = nm;
        ns[k] = nn;
    endtask

    task automatic compare(input int k);
        model_out(k);
        for (int b = 0; b < 7; b++) begin
            tests++;
            if (act[k][b] !== exp_o[k][b]) begin
                fails++;
                $display("FAIL %s inst%0d t=%0t actual=%b expected=%b",
                         tag_of(b), k, $time, act[k][b], exp_o[k][b]);
            end
        end
    endtask

    function automatic bit chance(int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic drive_random();
        head_valid      = chance(92);
        rob_at_head     = chance(70);
        head_committed  = chance(70);
        older_pending   = chance(60) ? '0 : CNT_W'(1 + $urandom % 3);
        head_flush      = chance(4);
        mmio_req_ready  = chance(50);
        mmio_resp_valid = chance(40);
        mmio_resp_err   = chance(30);
        nc_req_ready    = chance(50);
        nc_resp_valid   = chance(40);
        cmo_req_ready   = chance(50);
        cmo_resp_valid  = chance(40);
        sbf_flush_done  = chance(40);
        rob_commit      = chance(40);
        if (act[0][0] || chance(3)) head_kind = 2'($urandom % 4);
    endtask

    task automatic quiet();
        head_valid = 0; head_kind = 2'b00; rob_at_head = 0; head_committed = 0;
        older_pending = '0; head_flush = 0; mmio_req_ready = 0; mmio_resp_valid = 0;
        mmio_resp_err = 0; nc_req_ready = 0; nc_resp_valid = 0; cmo_req_ready = 0;
        cmo_resp_valid = 0; sbf_flush_done = 0; rob_commit = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        quiet();
        rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            ms[k] = 0; ns[k] = 0; m_cmo[k] = 0; m_drained[k] = 0; m_wbs[k] = 0; m_exc[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int k = 0; k < 2; k++) begin
            tests++;
            if (act[k] !== 7'b0) begin
                fails++;
                $display("FAIL R1 reset outputs inst%0d actual=%b expected=%b", k, act[k], 7'b0);
            end
        end
        for (int c = 0; c < N_CYCLES; c++) begin
            @(negedge clk);
            drive_random();
            #1;
            compare(0);
            compare(1);
            @(posedge clk);
            model_step(0);
            model_step(1);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule